// File: doc/BRIEF.md
# Conversion Result Window Filter

This block sits behind a converter and screens every finished conversion word before it reaches the result register. Two programmable thresholds, a low reference (`thr_a`) and a second reference (`thr_b`), together with two mode bits, define an acceptance window. A word that passes the screen is latched into the result register. It also sets the done flag. A word that fails is discarded with no trace: the result register and the flag stay as they were.

When screening is switched off, every word passes. The window itself can be "below A", "above A", an outside band or an inside band. The sense of the two band modes turns over when `thr_a` is larger than `thr_b`. Words and thresholds are compared as unsigned numbers for single-ended inputs, and as two's-complement numbers when the input is differential. Software clears the done flag by reading the result. An interrupt line follows the flag while interrupts are enabled.

Top module: `adc_window_cmp`

## Requirements
- R1: After reset, `result_q` is 0, and both `done` and `irq` are low.
- R2: With `cmp_on` low, every word presented with `res_valid` is stored in `result_q` and sets `done`.
- R3: A word that fails the window (with `cmp_on` high) leaves `result_q` unchanged and does not set `done`.
- R4: Mode 0 (`win_gt`=0, `win_rng`=0) accepts a word strictly less than `thr_a`.
- R5: Mode 1 (`win_gt`=1, `win_rng`=0) accepts a word strictly greater than `thr_a`.
- R6: Mode 2 (`win_gt`=0, `win_rng`=1) has two cases. If `thr_a` <= `thr_b`, it accepts a word that is < `thr_a` or > `thr_b`. Otherwise it accepts a word that is both < `thr_a` and > `thr_b`.
- R7: Mode 3 (`win_gt`=1, `win_rng`=1) has two cases. If `thr_a` <= `thr_b`, it accepts a word that is > `thr_a` and < `thr_b`. Otherwise it accepts a word that is > `thr_a` or < `thr_b`.
- R8: With `diff_in` high, the word and both thresholds are compared as 16-bit two's-complement values. With `diff_in` low, they are compared as unsigned values.
- R9: `rd_res` clears `done` on the next edge. If an accepted word arrives in the same cycle, `done` stays set and the new word is stored.
- R10: `irq` is high exactly while `done` is high and `irq_en` is high.
- R11: An accepted word shows on `result_q`, with `done` high, on the clock edge that samples its `res_valid` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Conversion word strobe |
| res_data | input | 16 | Conversion word |
| diff_in | input | 1 | Differential (signed) input |
| thr_a | input | 16 | First threshold |
| thr_b | input | 16 | Second threshold |
| cmp_on | input | 1 | Enable window screening |
| win_gt | input | 1 | Mode bit: greater-than |
| win_rng | input | 1 | Mode bit: band |
| irq_en | input | 1 | Interrupt enable |
| rd_res | input | 1 | Result read strobe |
| result_q | output | 16 | Stored result |
| done | output | 1 | Conversion done flag |
| irq | output | 1 | Interrupt request |

## Verification
A result read and the arrival of an accepted word can fall in the same cycle, and the new word must win that collision. The bench forces this collision in directed steps, and it also produces it at random by raising `rd_res` alongside `res_valid`. After the edge, it requires `done` to be high and `result_q` to hold the new word. When the same read meets a rejected word, `done` must instead drop and `result_q` must keep its old value.

// File: rtl/adc_window_cmp.sv
module adc_window_cmp #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res_valid,
  input  logic [DW-1:0] res_data,
  input  logic          diff_in,
  input  logic [DW-1:0] thr_a,
  input  logic [DW-1:0] thr_b,
  input  logic          cmp_on,
  input  logic          win_gt,
  input  logic          win_rng,
  input  logic          irq_en,
  input  logic          rd_res,
  output logic [DW-1:0] result_q,
  output logic          done,
  output logic          irq
);
  localparam int MSB = DW - 1;

  // Flipping the sign bit maps two's-complement order onto unsigned order.
  logic [DW-1:0] k_d, k_a, k_b;
  assign k_d = {res_data[MSB] ^ diff_in, res_data[MSB-1:0]};
  assign k_a = {thr_a[MSB] ^ diff_in, thr_a[MSB-1:0]};
  assign k_b = {thr_b[MSB] ^ diff_in, thr_b[MSB-1:0]};

  logic lt_a, gt_a, lt_b, gt_b, a_le_b, in_win, accept;
  assign lt_a   = k_d < k_a;
  assign gt_a   = k_d > k_a;
  assign lt_b   = k_d < k_b;
  assign gt_b   = k_d > k_b;
  assign a_le_b = k_a <= k_b;

  always_comb begin
    unique case ({win_rng, win_gt})
      2'b00:   in_win = lt_a;
      2'b01:   in_win = gt_a;
      2'b10:   in_win = a_le_b ? (lt_a | gt_b) : (lt_a & gt_b);
      default: in_win = a_le_b ? (gt_a & lt_b) : (gt_a | lt_b);
    endcase
  end

  assign accept = res_valid & (~cmp_on | in_win);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      done     <= 1'b0;
    end else if (accept) begin
      result_q <= res_data;
      done     <= 1'b1;
    end else if (rd_res) begin
      done     <= 1'b0;
    end
  end

  assign irq = done & irq_en;

  assert_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !cmp_on) |=> (done && result_q == $past(res_data)));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> $stable(result_q));

  assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_res && !res_valid) |=> !done);

  assert_rise_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(res_valid));

  assert_mode1_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && cmp_on && win_gt && !win_rng && !diff_in && res_data <= thr_a)
      |=> $stable(result_q));

  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);
endmodule

// File: tb/adc_window_cmp_tb_top.sv
module adc_window_cmp_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic res_valid = 0, diff_in = 0, cmp_on = 0, win_gt = 0, win_rng = 0, irq_en = 0, rd_res = 0;
  logic [15:0] res_data = 0, thr_a = 0, thr_b = 0;
  logic [15:0] result_q;
  logic done, irq;

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_res = 0;
  bit m_done = 0;

  always #5 clk = ~clk;

  adc_window_cmp dut_i (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .diff_in(diff_in), .thr_a(thr_a), .thr_b(thr_b), .cmp_on(cmp_on),
    .win_gt(win_gt), .win_rng(win_rng), .irq_en(irq_en), .rd_res(rd_res),
    .result_q(result_q), .done(done), .irq(irq));

  function automatic bit pass(logic [15:0] d, logic [15:0] a, logic [15:0] b,
                              bit sgn, bit en, bit gt, bit rng);
    int x, y, z;
    x = sgn ? int'($signed(d)) : int'(d);
    y = sgn ? int'($signed(a)) : int'(a);
    z = sgn ? int'($signed(b)) : int'(b);
    if (!en) return 1'b1;
    case ({rng, gt})
      2'b00: return x < y;
      2'b01: return x > y;
      2'b10: return (y <= z) ? (x < y || x > z) : (x < y && x > z);
      default: return (y <= z) ? (x > y && x < z) : (x > y || x < z);
    endcase
  endfunction

  function automatic string tag_of(bit en, bit gt, bit rng, bit sgn);
    if (!en) return "R2";
    if (sgn) return "R8";
    case ({rng, gt})
      2'b00: return "R4";
      2'b01: return "R5";
      2'b10: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(bit v, logic [15:0] d, logic [15:0] a, logic [15:0] b,
                      bit sgn, bit en, bit gt, bit rng, bit ie, bit rd);
    bit ok;
    string t;
    @(negedge clk);
    res_valid = v; res_data = d; thr_a = a; thr_b = b; diff_in = sgn;
    cmp_on = en; win_gt = gt; win_rng = rng; irq_en = ie; rd_res = rd;
    ok = v && pass(d, a, b, sgn, en, gt, rng);
    t = tag_of(en, gt, rng, sgn);
    if (ok) begin m_res = d; m_done = 1; end
    else if (rd) m_done = 0;
    @(negedge clk);
    res_valid = 0; rd_res = 0;
    if (v && rd) t = "R9";
    else if (v && !ok) t = "R3";
    chk({t, " R11 result"}, result_q, m_res);
    chk({t, " done"}, done, m_done);
    chk("R10 irq", irq, m_done & ie);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #12;
    chk("R1 result", result_q, 0);
    chk("R1 done", done, 0);
    chk("R1 irq", irq, 0);
    rst_n = 1;
    // R2: screening off accepts anything
    step(1, 16'hBEEF, 16'h0, 16'h0, 0, 0, 0, 0, 1, 0);
    // R9: read alone clears
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    // R4 boundary: equal to A is rejected, one below accepted
    step(1, 16'd100, 16'd100, 16'd0, 0, 1, 0, 0, 1, 0);
    step(1, 16'd99, 16'd100, 16'd0, 0, 1, 0, 0, 1, 0);
    // R5 boundary
    step(1, 16'd100, 16'd100, 16'd0, 0, 1, 1, 0, 0, 0);
    step(1, 16'd101, 16'd100, 16'd0, 0, 1, 1, 0, 0, 0);
    // R6 both orderings
    step(1, 16'd50, 16'd10, 16'd20, 0, 1, 0, 1, 1, 0);
    step(1, 16'd15, 16'd10, 16'd20, 0, 1, 0, 1, 1, 0);
    step(1, 16'd15, 16'd20, 16'd10, 0, 1, 0, 1, 1, 0);
    step(1, 16'd25, 16'd20, 16'd10, 0, 1, 0, 1, 1, 0);
    // R7 both orderings
    step(1, 16'd15, 16'd10, 16'd20, 0, 1, 1, 1, 1, 0);
    step(1, 16'd20, 16'd10, 16'd20, 0, 1, 1, 1, 1, 0);
    step(1, 16'd15, 16'd20, 16'd10, 0, 1, 1, 1, 1, 0);
    step(1, 16'd5, 16'd20, 16'd10, 0, 1, 1, 1, 1, 0);
    // R8: -1 is below 1 when signed, above when unsigned
    step(1, 16'hFFFF, 16'd1, 16'd0, 1, 1, 0, 0, 1, 0);
    step(1, 16'hFFFF, 16'd1, 16'd0, 0, 1, 0, 0, 1, 0);
    // R9 collision: accepted word wins over read; rejected word lets read clear
    step(1, 16'h1234, 16'd0, 16'd0, 0, 0, 0, 0, 1, 1);
    step(1, 16'h0005, 16'd1, 16'd0, 0, 1, 0, 0, 1, 1);
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a, b, d;
      a = 16'($urandom); b = 16'($urandom);
      case ($urandom_range(0, 3))
        0: d = a;
        1: d = b;
        2: d = a + 16'($urandom_range(0, 4)) - 16'd2;
        default: d = 16'($urandom);
      endcase
      step($urandom_range(0, 3) != 0, d, a, b, 1'($urandom), $urandom_range(0, 4) != 0,
           1'($urandom), 1'($urandom), 1'($urandom), $urandom_range(0, 3) == 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule